// File: doc/BRIEF.md
# Auto-Reload Down-Counter with Zero Event

This block is a 32-bit down-counter. It steps down by one on each cycle where the time-base tick enable is high. When a tick takes the count from one to zero, the block raises a zero event. The event sets a sticky pending flag. The flag drives a level interrupt whenever the interrupt enable is also high. A transition of the top bit does not raise the event. Only the arrival at zero does.

Software reaches the block through simple write strobes:
- One strobe loads the counter.
- A second strobe loads a separate reload register.
- A third strobe writes a status word. A one in bit 27 of that word clears the pending flag.

The reload enable and interrupt enable come in as plain level pins from the timer control register. When reload is enabled and the reload register is nonzero, the zero event puts the reload value into the counter instead of zero. This repeats the interval without software help. A zero reload value is never used, so the counter cannot retrigger itself without end. All pins are plain control and status pins. There is no data stream, so there is no valid/ready handshake and no back-pressure. Every strobe takes effect at the next clock edge.

Top module: `dec_timer`

## Requirements
- R1: After reset the count, the reload register and the pending flag are all zero, and `irq` is low.
- R2: On a clock edge with `tick` high, no counter load, and a count above one, the count drops by exactly one. Without `tick`, the count does not change.
- R3: A tick that finds the count at one, with no counter load in the same cycle, is a zero event and sets `pending`. A count of zero, whether loaded or reached earlier, raises no event on later ticks.
- R4: At a zero event with `reload_en` high and a nonzero reload register, the next count equals the reload register value.
- R5: At a zero event with `reload_en` high and a reload register of zero, the count goes to zero and stays there.
- R6: At a zero event with `reload_en` low, the count becomes zero. It holds at zero, and no further events occur until a counter load.
- R7: `irq` is high exactly when `pending` and `irq_en` are both high.
- R8: `pending` is cleared only by a status write whose bit 27 is one. Status writes with bit 27 zero have no effect on it, whatever the other bits hold.
- R9: When a zero event and a clearing status write fall in the same cycle, `pending` ends up set.
- R10: A counter load takes priority over a decrement or a reload in the same cycle. The loaded value appears, and a count of one under such a load raises no event.
- R11: Loading the counter while `pending` is set leaves `pending` set.
- R12: A reload register write shows on `reload_q` at the next edge. A zero event in the same cycle uses the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 32 | Counter load value |
| rld_wr | input | 1 | Reload register write strobe |
| rld_wdata | input | 32 | Reload register write value |
| reload_en | input | 1 | Auto-reload enable from the control register |
| irq_en | input | 1 | Interrupt enable from the control register |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 32 | Status write word; bit 27 set to one clears the flag |
| count | output | 32 | Current counter value |
| reload_q | output | 32 | Current reload register value |
| pending | output | 1 | Sticky zero-event flag |
| irq | output | 1 | Level interrupt |

## Verification
Two actions can land on the same edge, and both collisions are checked.

The first is a zero event and a software write. The bench fires a clearing status write on the same tick that takes the count from one to zero. It expects `pending` to stay set.

The second is a counter load and a decrement or reload on the same edge. The bench loads the counter on a tick that finds the count at one. It expects the loaded value and no event.

A reload register write in the event cycle is also checked. The count must take the old reload value. A behavioural model predicts every output on every clock, and each cycle is compared field by field.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int unsigned CLR_BIT = 27;
  localparam int unsigned STS_W   = 32;
endpackage

// File: rtl/dec_count.sv
module dec_count #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         rl_wr,
  input  logic [W-1:0] rl_val,
  input  logic         rl_en,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rl_q,
  output logic         zero_evt
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic         at_one, idle, use_rl;
  logic [W-1:0] nxt;

  assign at_one   = (cnt == ONE);
  assign idle     = (cnt == ZERO);
  assign zero_evt = tick && !ld && at_one;
  assign use_rl   = rl_en && (rl_q != ZERO);

  always_comb begin
    nxt = cnt;
    if (ld)                 nxt = ld_val;
    else if (tick && !idle) nxt = at_one ? (use_rl ? rl_q : ZERO) : cnt - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      rl_q <= '0;
    end else begin
      cnt <= nxt;
      if (rl_wr) rl_q <= rl_val;
    end
  end

  p_dec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && cnt > ONE) |=> (cnt == $past(cnt) - ONE));
  p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && rl_en && rl_q != ZERO) |=> (cnt == $past(rl_q)));
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !ld) |=> (cnt == ZERO));
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/dec_flag.sv
module dec_flag
  import dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             wr,
  input  logic [STS_W-1:0] wdata,
  output logic             flag
);
  logic clr;
  assign clr = wr && wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  p_no_self_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !evt) |=> !flag);
endmodule

// File: rtl/dec_timer.sv
module dec_timer
  import dec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [W-1:0]     cnt_wdata,
  input  logic             rld_wr,
  input  logic [W-1:0]     rld_wdata,
  input  logic             reload_en,
  input  logic             irq_en,
  input  logic             sts_wr,
  input  logic [STS_W-1:0] sts_wdata,
  output logic [W-1:0]     count,
  output logic [W-1:0]     reload_q,
  output logic             pending,
  output logic             irq
);
  logic evt;

  dec_count #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ld(cnt_wr), .ld_val(cnt_wdata),
    .rl_wr(rld_wr), .rl_val(rld_wdata), .rl_en(reload_en),
    .cnt(count), .rl_q(reload_q), .zero_evt(evt)
  );

  dec_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .wr(sts_wr), .wdata(sts_wdata), .flag(pending)
  );

  assign irq = pending & irq_en;

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  p_load_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && cnt_wr && !sts_wr) |=> pending);
endmodule

// File: tb/sim_dec_timer.sv
module sim_dec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 0, cnt_wr = 0, rld_wr = 0, reload_en = 0, irq_en = 0, sts_wr = 0;
  logic [31:0] cnt_wdata = 0, rld_wdata = 0, sts_wdata = 0;
  logic [31:0] count, reload_q;
  logic        pending, irq;

  int vec = 0, bad = 0;
  logic [31:0] m_cnt = 0, m_rld = 0;
  logic        m_sts = 0;

  always #10 clk = ~clk;

  dec_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .rld_wr(rld_wr), .rld_wdata(rld_wdata), .reload_en(reload_en), .irq_en(irq_en),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .count(count), .reload_q(reload_q), .pending(pending), .irq(irq)
  );

  task automatic compare(input string req);
    vec++;
    if (count !== m_cnt) begin bad++; $display("FAIL %s count act=%0d exp=%0d", req, count, m_cnt); end
    if (reload_q !== m_rld) begin bad++; $display("FAIL %s reload act=%0d exp=%0d", req, reload_q, m_rld); end
    if (pending !== m_sts) begin bad++; $display("FAIL %s pending act=%0b exp=%0b", req, pending, m_sts); end
    if (irq !== (m_sts & irq_en)) begin bad++; $display("FAIL %s irq act=%0b exp=%0b", req, irq, m_sts & irq_en); end
  endtask

  // one clock: inputs already set at negedge; model steps, then compare after edge
  task automatic step(input string req);
    logic        ev;
    logic [31:0] nc;
    ev = tick && !cnt_wr && (m_cnt == 1);
    if (cnt_wr) nc = cnt_wdata;
    else if (tick && m_cnt != 0)
      nc = (m_cnt == 1) ? ((reload_en && m_rld != 0) ? m_rld : 32'd0) : m_cnt - 1;
    else nc = m_cnt;
    if (ev) m_sts = 1'b1;
    else if (sts_wr && sts_wdata[27]) m_sts = 1'b0;
    if (rld_wr) m_rld = rld_wdata;
    m_cnt = nc;
    @(posedge clk);
    @(negedge clk);
    compare(req);
    tick = 0; cnt_wr = 0; rld_wr = 0; sts_wr = 0;
  endtask

  task automatic load(input logic [31:0] v, input string req);
    cnt_wr = 1; cnt_wdata = v; step(req);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) begin tick = 1; step(req); end
  endtask

  task automatic clear(input logic [31:0] w, input string req);
    sts_wr = 1; sts_wdata = w; step(req);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    compare("R1");
    rst_n = 1;
    step("R1");
    // plain countdown with idle gaps
    load(32'd4, "R10");
    ticks(1, "R2"); step("R2"); step("R2"); ticks(2, "R2");
    ticks(1, "R3");               // 1 -> 0 event
    ticks(3, "R6");               // held at zero, no new event
    irq_en = 1; step("R7");
    irq_en = 0; step("R7");
    irq_en = 1;
    clear(32'hF7FF_FFFF, "R8");   // bit 27 zero: no effect
    clear(32'h0800_0000, "R8");
    // load zero: no event
    load(32'd0, "R3"); ticks(2, "R3");
    // auto-reload nonzero
    rld_wr = 1; rld_wdata = 32'd3; step("R12");
    reload_en = 1;
    load(32'd2, "R10");
    ticks(2, "R4");
    ticks(3, "R4");
    clear(32'hFFFF_FFFF, "R8");
    // event and clear in same cycle
    ticks(2, "R4");
    tick = 1; sts_wr = 1; sts_wdata = 32'h0800_0000; step("R9");
    // load nonzero while pending
    load(32'd7, "R11");
    clear(32'h0800_0000, "R8");
    // load on a tick that finds count at one
    load(32'd1, "R10");
    tick = 1; cnt_wr = 1; cnt_wdata = 32'd9; step("R10");
    // reload write in the event cycle uses old value
    load(32'd1, "R12");
    tick = 1; rld_wr = 1; rld_wdata = 32'd6; step("R12");
    clear(32'h0800_0000, "R8");
    // reload of zero is skipped
    rld_wr = 1; rld_wdata = 32'd0; step("R12");
    load(32'd2, "R5");
    ticks(2, "R5");
    ticks(3, "R5");
    // reload disabled
    reload_en = 0; clear(32'h0800_0000, "R8");
    rld_wr = 1; rld_wdata = 32'd5; step("R12");
    load(32'd1, "R6"); ticks(1, "R6"); ticks(2, "R6");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule